// File: doc/BRIEF.md
# Immediate-Operand Execution Unit

This block is the execute step for instructions that carry a 16-bit constant inside the instruction word. It takes one 32-bit instruction and the value of its source register. From these it returns the computed result, the index of the destination register and a write strobe for the register file. It has no clock and no state. The caller reads the source register using the index the block decodes. It then presents that value and writes the result back when the strobe is high.

Four operations are handled: add a signed constant, set-on-signed-less-than a constant, OR a constant into the low half, and place a constant in the upper half. The operation decides how the 16-bit constant is widened to 32 bits. Two operations in a row build any 32-bit value: first the upper-half load, then an OR with the lower half.

Top module: `imm_exec_unit`

## Requirements
- R1: The instruction fields are: opcode in bits [31:26], source index in bits [25:21], destination index in bits [20:16] and constant in bits [15:0]. `src_idx` shows bits [25:21] and `dst_idx` shows bits [20:16] for every instruction.
- R2: Opcode 0x08 returns the source value plus the sign-extended constant, modulo 2^32. No overflow is flagged.
- R3: Opcode 0x0A returns 1 when the source is less than the sign-extended constant, both read as signed two's-complement numbers. Otherwise it returns 0. Bits [31:1] of the result are always 0.
- R4: Opcode 0x0D returns the source value ORed with the zero-extended constant. Bits [31:16] of the result equal those of the source.
- R5: Opcode 0x0F returns the constant in bits [31:16] and zero in bits [15:0]. The source value has no effect.
- R6: For any opcode other than the four above, `wr_en` is 0 and `result` is 0.
- R7: `wr_en` is 0 whenever the destination index is 0. Otherwise it is 1 for the four recognised opcodes.
- R8: Feeding the upper-half load result into an OR with a second constant yields the 32-bit value {first constant, second constant}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word to execute |
| src_val | input | 32 | Value read from the source register |
| src_idx | output | 5 | Source register index for the register-file read |
| result | output | 32 | Computed value for the destination |
| dst_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Register-file write strobe |

## Verification
The sweep crosses every one of the 64 opcodes with constants at the sign boundary (0x7FFF, 0x8000, 0xFFFF) and with sources at the signed extremes. It also uses destination indexes 0, 5 and 31. Each error shows up differently:
- A unit that zero-extends for add or compare gives results that are 65536 too large for negative constants.
- A unit that compares unsigned puts 0x80000000 above 0x7FFFFFFF.
- A unit that sign-extends for OR sets the upper half when the constant is 0x8000 or above.
- A unit that decodes loosely writes on unrelated opcodes or to register 0.

The two-step constant chain catches an upper-half load that leaves low bits set.

// File: rtl/imm_exec_pkg.sv
package imm_exec_pkg;
   typedef enum logic [5:0] {
      OPC_ADD_IMM = 6'h08,
      OPC_SLT_IMM = 6'h0A,
      OPC_OR_IMM  = 6'h0D,
      OPC_UPPER   = 6'h0F
   } imm_opc_e;

   typedef enum logic [1:0] {
      WIDEN_SIGNED,
      WIDEN_UNSIGNED,
      WIDEN_HIGH
   } widen_e;

   typedef enum logic [2:0] {
      FN_IDLE,
      FN_SUM,
      FN_LESS,
      FN_MERGE,
      FN_PASS
   } exec_fn_e;
endpackage

// File: rtl/imm_field_decode.sv
module imm_field_decode
   import imm_exec_pkg::*;
#(
   parameter int OPC_W = 6,
   parameter int IDX_W = 5,
   parameter int IMM_W = 16,
   localparam int INSTR_W = OPC_W + 2*IDX_W + IMM_W
) (
   input  logic [INSTR_W-1:0] instr,
   output logic [IDX_W-1:0]   rs_f,
   output logic [IDX_W-1:0]   rt_f,
   output logic [IMM_W-1:0]   imm_f,
   output exec_fn_e           fn,
   output widen_e             widen,
   output logic               known
);
   localparam int RT_LO  = IMM_W;
   localparam int RS_LO  = IMM_W + IDX_W;
   localparam int OPC_LO = IMM_W + 2*IDX_W;

   generate
      if (OPC_W != 6) begin : g_bad_opc
         $error("imm_field_decode: opcode width must be 6");
      end
   endgenerate

   logic [OPC_W-1:0] opc;

   assign opc   = instr[INSTR_W-1:OPC_LO];
   assign rs_f  = instr[OPC_LO-1:RS_LO];
   assign rt_f  = instr[RS_LO-1:RT_LO];
   assign imm_f = instr[IMM_W-1:0];

   always_comb begin
      fn    = FN_IDLE;
      widen = WIDEN_SIGNED;
      known = 1'b0;
      unique case (opc)
         OPC_ADD_IMM: begin fn = FN_SUM;   widen = WIDEN_SIGNED;   known = 1'b1; end
         OPC_SLT_IMM: begin fn = FN_LESS;  widen = WIDEN_SIGNED;   known = 1'b1; end
         OPC_OR_IMM:  begin fn = FN_MERGE; widen = WIDEN_UNSIGNED; known = 1'b1; end
         OPC_UPPER:   begin fn = FN_PASS;  widen = WIDEN_HIGH;     known = 1'b1; end
         default:     begin fn = FN_IDLE;  widen = WIDEN_SIGNED;   known = 1'b0; end
      endcase
   end
endmodule

// File: rtl/imm_widener.sv
module imm_widener
   import imm_exec_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int IMM_W = 16
) (
   input  logic [IMM_W-1:0] imm,
   input  widen_e           widen,
   output logic [XLEN-1:0]  wide
);
   localparam int PAD_W = XLEN - IMM_W;
   localparam int LOW_W = XLEN - IMM_W;

   logic [XLEN-1:0] w_sign, w_zero, w_high;

   generate
      if (XLEN < 2*IMM_W) begin : g_bad_width
         $error("imm_widener: XLEN must hold two constants");
      end
      if (PAD_W > 0) begin : g_pad
         assign w_sign = {{PAD_W{imm[IMM_W-1]}}, imm};
         assign w_zero = {{PAD_W{1'b0}}, imm};
      end else begin : g_nopad
         assign w_sign = imm;
         assign w_zero = imm;
      end
   endgenerate

   assign w_high = {imm, {LOW_W{1'b0}}};

   always_comb begin
      unique case (widen)
         WIDEN_UNSIGNED: wide = w_zero;
         WIDEN_HIGH:     wide = w_high;
         default:        wide = w_sign;
      endcase
   end
endmodule

// File: rtl/imm_alu.sv
module imm_alu
   import imm_exec_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  exec_fn_e        fn,
   output logic [XLEN-1:0] y
);
   logic [XLEN-1:0] sum;
   logic            less;

   assign sum  = a + b;
   assign less = ($signed(a) < $signed(b));

   always_comb begin
      unique case (fn)
         FN_SUM:   y = sum;
         FN_LESS:  y = {{(XLEN-1){1'b0}}, less};
         FN_MERGE: y = a | b;
         FN_PASS:  y = b;
         default:  y = '0;
      endcase
   end
endmodule

// File: rtl/imm_exec_unit.sv
module imm_exec_unit
   import imm_exec_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int OPC_W = 6,
   parameter int IDX_W = 5,
   parameter int IMM_W = 16,
   localparam int INSTR_W = OPC_W + 2*IDX_W + IMM_W
) (
   input  logic [INSTR_W-1:0] instr,
   input  logic [XLEN-1:0]    src_val,
   output logic [IDX_W-1:0]   src_idx,
   output logic [XLEN-1:0]    result,
   output logic [IDX_W-1:0]   dst_idx,
   output logic               wr_en
);
   exec_fn_e         fn;
   widen_e           widen;
   logic             known;
   logic [IMM_W-1:0] imm_f;
   logic [XLEN-1:0]  imm_wide;

   imm_field_decode #(.OPC_W(OPC_W), .IDX_W(IDX_W), .IMM_W(IMM_W)) u_dec (
      .instr(instr), .rs_f(src_idx), .rt_f(dst_idx), .imm_f(imm_f),
      .fn(fn), .widen(widen), .known(known)
   );

   imm_widener #(.XLEN(XLEN), .IMM_W(IMM_W)) u_wid (
      .imm(imm_f), .widen(widen), .wide(imm_wide)
   );

   imm_alu #(.XLEN(XLEN)) u_alu (
      .a(src_val), .b(imm_wide), .fn(fn), .y(result)
   );

   assign wr_en = known && (dst_idx != '0);
endmodule

// File: rtl/imm_exec_checks.sv
module imm_exec_checks #(
   parameter int XLEN  = 32,
   parameter int OPC_W = 6,
   parameter int IDX_W = 5,
   parameter int IMM_W = 16,
   localparam int INSTR_W = OPC_W + 2*IDX_W + IMM_W
) (
   input logic [INSTR_W-1:0] instr,
   input logic [XLEN-1:0]    src_val,
   input logic [IDX_W-1:0]   src_idx,
   input logic [XLEN-1:0]    result,
   input logic [IDX_W-1:0]   dst_idx,
   input logic               wr_en
);
   logic [OPC_W-1:0] op;
   logic             recog;
   assign op    = instr[INSTR_W-1:INSTR_W-OPC_W];
   assign recog = (op == 6'h08) || (op == 6'h0A) || (op == 6'h0D) || (op == 6'h0F);

   always_comb begin
      // R1
      a_r1_fields: assert (dst_idx == instr[20:16] && src_idx == instr[25:21]);
      // R7
      if (instr[20:16] == '0) a_r7_zero_dst: assert (!wr_en);
      // R6
      if (!recog) a_r6_unknown: assert (!wr_en && result == '0);
      // R3
      if (op == 6'h0A) a_r3_boolean: assert (result[XLEN-1:1] == '0);
      // R5
      if (op == 6'h0F) a_r5_low_clear: assert (result[15:0] == 16'h0);
      // R4
      if (op == 6'h0D) a_r4_upper_kept: assert (result[31:16] == src_val[31:16]);
   end
endmodule

bind imm_exec_unit imm_exec_checks #(
   .XLEN(XLEN), .OPC_W(OPC_W), .IDX_W(IDX_W), .IMM_W(IMM_W)
) u_checks (
   .instr(instr), .src_val(src_val), .src_idx(src_idx),
   .result(result), .dst_idx(dst_idx), .wr_en(wr_en)
);

// File: tb/test_imm_exec_unit.sv
module test_imm_exec_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = '0;
   logic [31:0] src_val = '0;
   logic [4:0]  src_idx, dst_idx;
   logic [31:0] result;
   logic        wr_en;

   int n_vec = 0;
   int n_bad = 0;
   int ticks = 0;
   bit done = 0;

   always #5 clk = ~clk;

   imm_exec_unit i_imm_exec_unit (
      .instr(instr), .src_val(src_val), .src_idx(src_idx),
      .result(result), .dst_idx(dst_idx), .wr_en(wr_en)
   );

   always @(posedge clk) begin
      ticks <= ticks + 1;
      if (ticks > 150000 && !done) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog: run did not finish, got %0d ticks expected < 150000", ticks);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: instr=%h src=%h actual=%h expected=%h", req, instr, src_val, act, exp);
      end
   endtask

   task automatic apply(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt,
                        input logic [15:0] imm, input logic [31:0] src);
      longint simm, s_src, e;
      logic [31:0] exp_res;
      logic        exp_we;
      instr   = {op, rs, rt, imm};
      src_val = src;
      #2;
      simm  = imm[15] ? longint'(imm) - 65536 : longint'(imm);
      s_src = src[31] ? longint'(src) - 64'd4294967296 : longint'(src);
      exp_we = 1'b1;
      case (op)
         6'h08: begin e = longint'(src) + simm; exp_res = e[31:0]; end   // R2
         6'h0A: exp_res = (s_src < simm) ? 32'd1 : 32'd0;               // R3
         6'h0D: exp_res = src | {16'h0, imm};                           // R4
         6'h0F: exp_res = {16'h0, imm} * 32'd65536;                      // R5
         default: begin exp_res = 32'd0; exp_we = 1'b0; end             // R6
      endcase
      if (rt == 5'd0) exp_we = 1'b0;                                    // R7
      check("R1_dst", {27'd0, dst_idx}, {27'd0, rt});
      check("R1_src", {27'd0, src_idx}, {27'd0, rs});
      check(op == 6'h08 ? "R2" : op == 6'h0A ? "R3" : op == 6'h0D ? "R4" :
            op == 6'h0F ? "R5" : "R6", result, exp_res);
      check(rt == 0 ? "R7" : "R6_R7_we", {31'd0, wr_en}, {31'd0, exp_we});
      #3;
   endtask

   logic [15:0] imms [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
   logic [31:0] srcs [7] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF,
                             32'hFFFF8000, 32'hA5A50F0F};
   logic [4:0]  rts  [3] = '{5'd0, 5'd5, 5'd31};

   initial begin
      // reset state: all-zero instruction must not write
      repeat (2) @(negedge clk);
      rst = 1'b0;
      #1;
      check("R6_reset", {31'd0, wr_en}, 32'd0);
      check("R6_reset", result, 32'd0);

      for (int op = 0; op < 64; op++)
         for (int i = 0; i < 6; i++)
            for (int s = 0; s < 7; s++)
               for (int r = 0; r < 3; r++)
                  apply(op[5:0], 5'(s + 3 * r), rts[r], imms[i], srcs[s]);

      // R8: build constants with upper load then OR
      for (int k = 0; k < 24; k++) begin
         logic [15:0] hi, lo;
         logic [31:0] mid;
         hi = 16'(k * 16'h2B1D + 16'h8001);
         lo = 16'(k * 16'h4E37 + 16'hFFF0);
         apply(6'h0F, 5'd0, 5'd9, hi, 32'hDEADBEEF);
         mid = result;
         apply(6'h0D, 5'd9, 5'd9, lo, mid);
         check("R8", result, {hi, lo});
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule